// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block takes a single idle-high serial line and turns each asynchronous character on it into a parallel byte. A baud tick arriving at sixteen times the bit rate paces the sampling. The block locks its bit timing to the falling edge of each start bit and confirms the start bit at its centre. It then samples the data bits (least significant first), an optional parity bit and the stop bit at their centres. Configuration inputs choose the character length (full width or one bit shorter), parity on or off, odd or even parity, and one or two stop bits.

When a character ends, the block decides how to update its visible state. A clean character lands in the data register and raises the data-full flag. A parity or stop-bit fault still delivers the byte, but it raises a sticky error flag in place of the data-full flag. A character that ends while the data-full flag is still set is lost and raises the overrun flag. While any error flag stands, new characters are ignored. Software clears flags through a masked write port. Two interrupt lines, one for data-full and one for errors, share one enable input.

The frame state machine has the states IDLE, START, DATA, PARITY, STOP and STOP2. IDLE goes to START on a tick that sees the line low while reception is not held. START goes back to IDLE if the line is high at mid-bit, and otherwise goes to DATA. DATA goes to PARITY after the last data bit when parity is on, and to STOP when it is off. PARITY goes to STOP. STOP goes to STOP2 when two stop bits are set, and otherwise goes to IDLE. STOP2 goes to IDLE.

Top module: `serial_rx_core`

## Requirements
- R1: After reset the data register reads 0, and all four flags and both interrupt lines are 0.
- R2: A low level on the line counts as a start bit only if it is still low at the eighth baud tick after it was first seen. A shorter low pulse changes nothing at the outputs, and a later valid character is still received.
- R3: Data bits are received least significant bit first. With `cfg_short_char` set, 7 bits are received and bit 7 of the data register reads 0.
- R4: With `cfg_parity_en` set, one parity bit follows the data. The total number of ones in the data and parity bits must be odd when `cfg_parity_odd` is 1 and even when it is 0. A mismatch sets `flag_parity`.
- R5: A first stop bit sampled as 0 sets `flag_framing`. When `cfg_two_stop` is set, the value of the second stop bit is never checked.
- R6: A character with no error and no overrun is copied into `rx_data`, and `flag_full` is set.
- R7: If `flag_full` is still 1 when a character ends, `flag_overrun` is set and `rx_data` keeps its old value.
- R8: On a parity or framing error without overrun, the byte is copied into `rx_data` and `flag_full` stays 0.
- R9: While any of `flag_overrun`, `flag_framing` or `flag_parity` is 1, arriving characters are ignored and change no output.
- R10: A write with `sw_we` high clears each flag whose `sw_wmask` bit is 1 and whose `sw_wdata` bit is 0. The bit positions are: bit 0 for `flag_full`, bit 1 for `flag_overrun`, bit 2 for `flag_framing` and bit 3 for `flag_parity`. A mask bit written with data 1 has no effect.
- R11: `irq_full` is 1 exactly while `flag_full` and `irq_en` are both 1. `irq_err` is 1 exactly while `irq_en` is 1 and any error flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_in | input | 1 | Serial line, idle high, asynchronous |
| baud_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| cfg_parity_en | input | 1 | Parity bit present |
| cfg_parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | Two stop bits per character |
| cfg_short_char | input | 1 | Character is DATA_W-1 bits |
| irq_en | input | 1 | Enable for both interrupt lines |
| sw_we | input | 1 | Flag write strobe |
| sw_wmask | input | 4 | Selects the flags touched by the write |
| sw_wdata | input | 4 | 0 in a selected bit clears that flag |
| rx_data | output | DATA_W | Received data register |
| flag_full | output | 1 | Data-full flag |
| flag_overrun | output | 1 | Overrun error flag |
| flag_framing | output | 1 | Framing error flag |
| flag_parity | output | 1 | Parity error flag |
| irq_full | output | 1 | Data-full interrupt |
| irq_err | output | 1 | Receive-error interrupt |

## Verification
The assertions assume that `baud_tick` is a single-cycle strobe in the clock domain. They also assume that configuration inputs do not change while a character is in flight, and that software does not write the flags in the same cycle that a character commits. The stimulus meets these conditions. It ticks every second clock and changes configuration only between characters. It issues flag writes only on an idle line, after the commit point of the last character. The bench leaves out its per-clock comparison during each stop bit, the only stretch in which the exact commit cycle can differ.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_STOP2
    } rx_state_e;

    localparam int NFLAGS   = 4;
    localparam int FLAG_FUL = 0;
    localparam int FLAG_OVR = 1;
    localparam int FLAG_FRM = 2;
    localparam int FLAG_PAR = 3;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '1;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], din};
        end
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
    import srx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_s,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              cfg_short,
    input  logic              hold,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] done_data_o,
    output logic              done_par_o,
    output logic              done_frm_o
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] MID_CNT   = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] END_CNT   = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] IDX_LONG  = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] IDX_SHORT = IDX_W'(DATA_W - 2);

    rx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  os_cnt_q;
    logic [IDX_W-1:0]  bit_idx_q;
    logic [DATA_W-1:0] shift_q;
    logic              ones_q;
    logic [IDX_W-1:0]  last_idx;
    logic              bit_mid;
    logic              start_mid;
    logic              last_bit;
    logic [CNT_W-1:0]  cnt_next;

    assign last_idx  = cfg_short ? IDX_SHORT : IDX_LONG;
    assign bit_mid   = tick && (os_cnt_q == END_CNT);
    assign start_mid = tick && (os_cnt_q == MID_CNT);
    assign last_bit  = (bit_idx_q == last_idx);
    assign cnt_next  = (os_cnt_q == END_CNT) ? '0 : os_cnt_q + 1'b1;
    assign busy_o    = (state_q != RX_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:   if (tick && !rx_s && !hold) state_d = RX_START;
            RX_START:  if (start_mid) state_d = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:   if (bit_mid && last_bit)
                           state_d = cfg_par_en ? RX_PARITY : RX_STOP;
            RX_PARITY: if (bit_mid) state_d = RX_STOP;
            RX_STOP:   if (bit_mid) state_d = cfg_two_stop ? RX_STOP2 : RX_IDLE;
            RX_STOP2:  if (bit_mid) state_d = RX_IDLE;
            default:   state_d = RX_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_cnt_q    <= '0;
            bit_idx_q   <= '0;
            shift_q     <= '0;
            ones_q      <= 1'b0;
            done_o      <= 1'b0;
            done_data_o <= '0;
            done_par_o  <= 1'b0;
            done_frm_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    os_cnt_q <= '0;
                end
                RX_START: begin
                    if (start_mid) begin
                        os_cnt_q  <= '0;
                        bit_idx_q <= '0;
                        shift_q   <= '0;
                        ones_q    <= 1'b0;
                    end else if (tick) begin
                        os_cnt_q <= os_cnt_q + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (tick) os_cnt_q <= cnt_next;
                    if (bit_mid) begin
                        shift_q[bit_idx_q] <= rx_s;
                        ones_q             <= ones_q ^ rx_s;
                        bit_idx_q          <= bit_idx_q + 1'b1;
                    end
                end
                RX_PARITY: begin
                    if (tick) os_cnt_q <= cnt_next;
                    if (bit_mid) ones_q <= ones_q ^ rx_s;
                end
                RX_STOP: begin
                    if (tick) os_cnt_q <= cnt_next;
                    if (bit_mid) begin
                        done_o      <= 1'b1;
                        done_data_o <= shift_q;
                        done_frm_o  <= !rx_s;
                        done_par_o  <= cfg_par_en && (ones_q != cfg_par_odd);
                    end
                end
                RX_STOP2: begin
                    if (tick) os_cnt_q <= cnt_next;
                end
                default: os_cnt_q <= '0;
            endcase
        end
    end
endmodule

// File: rtl/srx_status.sv
module srx_status
    import srx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [DATA_W-1:0] commit_data,
    input  logic              commit_par,
    input  logic              commit_frm,
    input  logic              sw_we,
    input  logic [NFLAGS-1:0] sw_wmask,
    input  logic [NFLAGS-1:0] sw_wdata,
    input  logic              irq_en,
    output logic [DATA_W-1:0] data_o,
    output logic [NFLAGS-1:0] flags_o,
    output logic              err_any_o,
    output logic              irq_full_o,
    output logic              irq_err_o
);
    logic [NFLAGS-1:0] flags_q, flags_d;
    logic [DATA_W-1:0] data_q, data_d;
    logic              overrun;

    assign overrun = flags_q[FLAG_FUL];

    always_comb begin
        flags_d = flags_q;
        data_d  = data_q;
        if (sw_we) begin
            for (int i = 0; i < NFLAGS; i++) begin
                if (sw_wmask[i] && !sw_wdata[i]) flags_d[i] = 1'b0;
            end
        end
        if (commit) begin
            if (overrun) flags_d[FLAG_OVR] = 1'b1;
            else         data_d = commit_data;
            if (commit_par) flags_d[FLAG_PAR] = 1'b1;
            if (commit_frm) flags_d[FLAG_FRM] = 1'b1;
            if (!overrun && !commit_par && !commit_frm) flags_d[FLAG_FUL] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            data_q  <= '0;
        end else begin
            flags_q <= flags_d;
            data_q  <= data_d;
        end
    end

    assign data_o     = data_q;
    assign flags_o    = flags_q;
    assign err_any_o  = flags_q[FLAG_OVR] | flags_q[FLAG_FRM] | flags_q[FLAG_PAR];
    assign irq_full_o = irq_en & flags_q[FLAG_FUL];
    assign irq_err_o  = irq_en & err_any_o;
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import srx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic              baud_tick,
    input  logic              cfg_parity_en,
    input  logic              cfg_parity_odd,
    input  logic              cfg_two_stop,
    input  logic              cfg_short_char,
    input  logic              irq_en,
    input  logic              sw_we,
    input  logic [3:0]        sw_wmask,
    input  logic [3:0]        sw_wdata,
    output logic [DATA_W-1:0] rx_data,
    output logic              flag_full,
    output logic              flag_overrun,
    output logic              flag_framing,
    output logic              flag_parity,
    output logic              irq_full,
    output logic              irq_err
);
    logic              rx_s;
    logic              commit;
    logic [DATA_W-1:0] commit_data;
    logic              commit_par;
    logic              commit_frm;
    logic              err_any;
    logic              frame_busy;
    logic [NFLAGS-1:0] flags;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_in),
        .dout (rx_s)
    );

    srx_frame_fsm #(.DATA_W(DATA_W), .OVS(OVS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (baud_tick),
        .rx_s        (rx_s),
        .cfg_par_en  (cfg_parity_en),
        .cfg_par_odd (cfg_parity_odd),
        .cfg_two_stop(cfg_two_stop),
        .cfg_short   (cfg_short_char),
        .hold        (err_any | commit),
        .busy_o      (frame_busy),
        .done_o      (commit),
        .done_data_o (commit_data),
        .done_par_o  (commit_par),
        .done_frm_o  (commit_frm)
    );

    srx_status #(.DATA_W(DATA_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .commit_data(commit_data),
        .commit_par (commit_par),
        .commit_frm (commit_frm),
        .sw_we      (sw_we),
        .sw_wmask   (sw_wmask),
        .sw_wdata   (sw_wdata),
        .irq_en     (irq_en),
        .data_o     (rx_data),
        .flags_o    (flags),
        .err_any_o  (err_any),
        .irq_full_o (irq_full),
        .irq_err_o  (irq_err)
    );

    assign flag_full    = flags[FLAG_FUL];
    assign flag_overrun = flags[FLAG_OVR];
    assign flag_framing = flags[FLAG_FRM];
    assign flag_parity  = flags[FLAG_PAR];
endmodule

// File: rtl/serial_rx_core_checker.sv
module serial_rx_core_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_en,
    input logic              sw_we,
    input logic [3:0]        sw_wmask,
    input logic [3:0]        sw_wdata,
    input logic [DATA_W-1:0] rx_data,
    input logic              flag_full,
    input logic              flag_overrun,
    input logic              flag_framing,
    input logic              flag_parity,
    input logic              irq_full,
    input logic              irq_err,
    input logic              commit,
    input logic              frame_busy,
    input logic              err_any
);
    logic errs;
    assign errs = flag_overrun | flag_framing | flag_parity;

    assert_full_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_full) |-> !errs);

    assert_overrun_keeps_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_overrun) |-> $stable(rx_data));

    assert_flags_at_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_framing) || $rose(flag_parity) || $rose(flag_full)) |-> $past(commit));

    assert_blocked_stays_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_busy && err_any) |=> !frame_busy);

    assert_clear_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && sw_wmask[0] && !sw_wdata[0] && !commit) |=> !flag_full);

    assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> (!irq_full && !irq_err));

    assert_irq_err_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> errs);
endmodule

bind serial_rx_core serial_rx_core_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_en      (irq_en),
    .sw_we       (sw_we),
    .sw_wmask    (sw_wmask),
    .sw_wdata    (sw_wdata),
    .rx_data     (rx_data),
    .flag_full   (flag_full),
    .flag_overrun(flag_overrun),
    .flag_framing(flag_framing),
    .flag_parity (flag_parity),
    .irq_full    (irq_full),
    .irq_err     (irq_err),
    .commit      (commit),
    .frame_busy  (frame_busy),
    .err_any     (err_any)
);

// File: tb/serial_rx_core_bench.sv
`timescale 1ns/1ps
module serial_rx_core_bench;
    localparam int BIT_CLK = 32;
    localparam int MAX_CYC = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_in = 1'b1;
    logic       baud_tick = 1'b0;
    logic       cfg_parity_en = 1'b0;
    logic       cfg_parity_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_short_char = 1'b0;
    logic       irq_en = 1'b0;
    logic       sw_we = 1'b0;
    logic [3:0] sw_wmask = 4'h0;
    logic [3:0] sw_wdata = 4'h0;
    logic [7:0] rx_data;
    logic       flag_full, flag_overrun, flag_framing, flag_parity;
    logic       irq_full, irq_err;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   cmp_on = 1'b0;
    bit   finished = 1'b0;
    logic [7:0] e_data = 8'h00;
    logic [3:0] e_flags = 4'h0;   // 0 full, 1 overrun, 2 framing, 3 parity

    serial_rx_core u_serial_rx_core (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .baud_tick(baud_tick),
        .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
        .cfg_two_stop(cfg_two_stop), .cfg_short_char(cfg_short_char),
        .irq_en(irq_en), .sw_we(sw_we), .sw_wmask(sw_wmask), .sw_wdata(sw_wdata),
        .rx_data(rx_data), .flag_full(flag_full), .flag_overrun(flag_overrun),
        .flag_framing(flag_framing), .flag_parity(flag_parity),
        .irq_full(irq_full), .irq_err(irq_err)
    );

    initial forever #2.5 clk = ~clk;

    initial forever begin
        @(negedge clk);
        baud_tick = ~baud_tick;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // per-clock comparison against the behavioural model
    initial forever begin
        @(posedge clk);
        #1;
        if (cmp_on) begin
            chk("R3 data register", rx_data, e_data);
            chk("R6 full flag", flag_full, e_flags[0]);
            chk("R7 overrun flag", flag_overrun, e_flags[1]);
            chk("R5 framing flag", flag_framing, e_flags[2]);
            chk("R4 parity flag", flag_parity, e_flags[3]);
            chk("R11 irq_full", irq_full, e_flags[0] & irq_en);
            chk("R11 irq_err", irq_err, (|e_flags[3:1]) & irq_en);
        end
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        finish_run();
    end

    task automatic drive_bit(input logic b);
        @(negedge clk);
        rx_in = b;
        repeat (BIT_CLK - 1) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit flip_par,
                              input bit stop1, input bit stop2);
        int         nb;
        logic [7:0] de;
        bit         pbit;
        bit         blocked;
        bit         perr;
        bit         ovr;
        nb      = cfg_short_char ? 7 : 8;
        de      = cfg_short_char ? (d & 8'h7f) : d;
        pbit    = (^de) ^ cfg_parity_odd ^ flip_par;
        blocked = |e_flags[3:1];
        perr    = cfg_parity_en && flip_par;
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(de[i]);
        if (cfg_parity_en) drive_bit(pbit);
        cmp_on = 1'b0;
        drive_bit(stop1);
        if (!blocked) begin
            ovr = e_flags[0];
            if (ovr) e_flags[1] = 1'b1;
            else     e_data = de;
            if (perr)   e_flags[3] = 1'b1;
            if (!stop1) e_flags[2] = 1'b1;
            if (!ovr && !perr && stop1) e_flags[0] = 1'b1;
        end
        cmp_on = 1'b1;
        if (cfg_two_stop) drive_bit(stop2);
        drive_bit(1'b1);
    endtask

    task automatic sw_write(input logic [3:0] m, input logic [3:0] v);
        @(negedge clk);
        sw_we = 1'b1;
        sw_wmask = m;
        sw_wdata = v;
        for (int i = 0; i < 4; i++) if (m[i] && !v[i]) e_flags[i] = 1'b0;
        @(negedge clk);
        sw_we = 1'b0;
        sw_wmask = 4'h0;
        sw_wdata = 4'h0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset data", rx_data, 8'h00);
        chk("R1 reset flags", {flag_full, flag_overrun, flag_framing, flag_parity}, 4'h0);
        chk("R1 reset irqs", {irq_full, irq_err}, 2'b00);
        cmp_on = 1'b1;
        irq_en = 1'b1;

        send_frame(8'hA5, 1'b0, 1'b1, 1'b1);
        chk("R6 clean frame full", flag_full, 1'b1);
        chk("R3 lsb first byte", rx_data, 8'hA5);
        chk("R11 irq_full on", irq_full, 1'b1);

        send_frame(8'h3C, 1'b0, 1'b1, 1'b1);
        chk("R7 overrun keeps old data", rx_data, 8'hA5);
        chk("R7 overrun flag set", flag_overrun, 1'b1);
        chk("R11 irq_err on", irq_err, 1'b1);

        send_frame(8'h11, 1'b0, 1'b1, 1'b1);
        chk("R9 blocked frame ignored", rx_data, 8'hA5);

        sw_write(4'hF, 4'hF);
        chk("R10 writing ones no effect", {flag_full, flag_overrun}, 2'b11);
        sw_write(4'b0011, 4'b0000);
        chk("R10 flags cleared", {flag_full, flag_overrun}, 2'b00);
        chk("R9 blocked byte never arrived", rx_data, 8'hA5);

        cfg_parity_en = 1'b1;
        cfg_parity_odd = 1'b0;
        send_frame(8'h5A, 1'b0, 1'b1, 1'b1);
        chk("R4 even parity passes", {flag_full, flag_parity}, 2'b10);
        sw_write(4'b0001, 4'b0000);

        cfg_parity_odd = 1'b1;
        send_frame(8'h07, 1'b0, 1'b1, 1'b1);
        chk("R4 odd parity passes", {flag_full, flag_parity}, 2'b10);
        chk("R4 odd parity data", rx_data, 8'h07);
        sw_write(4'b0001, 4'b0000);

        send_frame(8'h80, 1'b1, 1'b1, 1'b1);
        chk("R4 parity mismatch flag", flag_parity, 1'b1);
        chk("R8 parity error data copied", rx_data, 8'h80);
        chk("R8 parity error no full", flag_full, 1'b0);
        sw_write(4'b1000, 4'b0000);

        cfg_parity_en = 1'b0;
        send_frame(8'h42, 1'b0, 1'b0, 1'b1);
        chk("R5 framing flag", flag_framing, 1'b1);
        chk("R8 framing data copied", rx_data, 8'h42);
        chk("R8 framing no full", flag_full, 1'b0);
        sw_write(4'b0100, 4'b0000);

        cfg_two_stop = 1'b1;
        send_frame(8'h99, 1'b0, 1'b1, 1'b0);
        chk("R5 second stop unchecked", {flag_full, flag_framing}, 2'b10);
        chk("R5 two stop data", rx_data, 8'h99);
        sw_write(4'b0001, 4'b0000);
        cfg_two_stop = 1'b0;

        cfg_short_char = 1'b1;
        send_frame(8'hFF, 1'b0, 1'b1, 1'b1);
        chk("R3 short char top bit zero", rx_data, 8'h7F);
        sw_write(4'b0001, 4'b0000);
        cfg_short_char = 1'b0;

        @(negedge clk);
        rx_in = 1'b0;
        repeat (10) @(negedge clk);
        rx_in = 1'b1;
        repeat (3 * BIT_CLK) @(negedge clk);
        chk("R2 glitch ignored data", rx_data, 8'h7F);
        chk("R2 glitch ignored flags", {flag_full, flag_overrun, flag_framing, flag_parity}, 4'h0);
        send_frame(8'hC3, 1'b0, 1'b1, 1'b1);
        chk("R2 receive after glitch", rx_data, 8'hC3);

        @(negedge clk);
        irq_en = 1'b0;
        @(negedge clk);
        chk("R11 irq_full gated off", irq_full, 1'b0);
        irq_en = 1'b1;
        @(negedge clk);
        chk("R11 irq_full enabled", irq_full, 1'b1);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule